// File: doc/BRIEF.md
# Vector Chaining Issue Controller

This block sits between a decoded vector instruction stream and three functional units (a load unit, a multiply unit and an add unit) that share a vector register file. It accepts instructions in program order and starts each one on its unit. It then tells the unit, one clock at a time, when it may advance to its next element. For every architectural vector register it keeps a count of how many leading elements are already valid. A consumer steps element `i` only once that count for each of its sources is above `i`. A dependent instruction can therefore begin while its producer is still streaming results, and load, multiply and add run overlapped.

Each unit has a fixed write-back latency: 12 clocks for a load, 7 for a multiply and 6 for an add. Each unit returns one element per clock after that latency. A unit raises a write strobe for each element when that element lands in the register file. The controller counts these strobes per destination register. When the unit's last element has landed, the destination is marked fully available.

Instructions enter over a valid/ready port. `in_ready` is computed from the offered instruction's fields and from the busy state of the units. When `in_valid` is high and `in_ready` is low, the source must hold the fields stable and keep `in_valid` high until the transfer completes. An instruction transfers in a cycle where both are high. At most one instruction transfers per clock.

Top module: `vchain_issue`

## Requirements
- R1: After reset, `in_ready` is high for any offered instruction, and `unit_start`, `unit_adv` and `unit_wr` are all zero.
- R2: `in_op` encodes the unit as 0 = load (unit 0), 1 = multiply (unit 1) and 2 = add (unit 2); code 3 is also routed to the add unit. In the transfer cycle, exactly that unit's bit of `unit_start` is high.
- R3: A started unit raises `unit_adv` for element indices 0 to len-1 in ascending order, at most one per clock. A load, which has no register sources, advances on every clock starting with the cycle after transfer.
- R4: Each element write strobe on `unit_wr` follows that element's advance by exactly the unit's latency: 12 cycles for load, 7 for multiply, 6 for add.
- R5: A consumer advances element i in the cycle after its producer's write strobe for element i, provided the consumer is already started. When the chain is load, multiply, add, with each instruction transferred one clock after the previous one, the multiply's element i advances 13 cycles after the load's element i, and the add's element i advances 8 cycles after the multiply's element i.
- R6: An instruction for a unit that is still busy is held (`in_ready` low) until the cycle after that unit's final write strobe. A load of length L accepted in cycle A lets the next load transfer in cycle A+L+13.
- R7: An instruction whose destination is the destination of a busy unit is held until the cycle after that unit's final write strobe.
- R8: An instruction whose destination is a source of a busy multiply or add is held until the cycle after that unit's final write strobe.
- R9: A read-after-write dependence on a busy unit's destination does not hold the transfer: a chain of dependent instructions on distinct units transfers on consecutive cycles.
- R10: A source register equal to the instruction's own destination is read without waiting, so its elements advance one per clock from the cycle after transfer.
- R11: A register with no writer in flight is fully available: a consumer reading only such registers advances from the cycle after transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction may transfer this cycle |
| in_op | input | 2 | Unit select: 0 load, 1 multiply, 2 or 3 add |
| in_vd | input | RW | Destination vector register |
| in_vs1 | input | RW | First source register (unused by load) |
| in_vs2 | input | RW | Second source register (unused by load) |
| in_len | input | LENW | Element count, 0 to VLMAX |
| unit_start | output | 3 | One-cycle start, one bit per unit |
| unit_adv | output | 3 | Element advance, one bit per unit |
| unit_idx | output | 3*LENW | Element index being advanced, LENW bits per unit |
| unit_wr | output | 3 | Element write strobe, one bit per unit |

## Verification
The bench targets the exact chained timing of a load-multiply-add stream of 16 elements. If the design gated on whole-register completion, the multiply would start about 16 cycles late. If it tested the count off by one, every element would shift by a cycle, or a consumer would read an element that has not been written. The three stall cases (structural, write-after-write and write-after-read) are each checked at their exact release cycle. A design that freed the unit on its last advance instead of its last write would release too early. A design that stalled on read-after-write would stop the chain transferring back to back. The remaining cases cover a register that reads itself, reads of idle registers, and the reserved op code. A design that waited on its own destination would deadlock. A design that lost the fully-available mark would hang a reader.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  localparam int NUNITS = 3;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_MUL  = 2'd1,
    OP_ADD  = 2'd2,
    OP_RSVD = 2'd3
  } vop_e;

  function automatic int unit_of(input logic [1:0] op);
    case (op)
      OP_LOAD: return 0;
      OP_MUL:  return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/vchain_avail.sv
module vchain_avail #(
  parameter int NREG  = 8,
  parameter int VLMAX = 16,
  parameter int NU    = 3,
  localparam int RW   = $clog2(NREG),
  localparam int LENW = $clog2(VLMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_reg,
  input  logic [NU-1:0]   inc_en,
  input  logic [RW-1:0]   inc_reg [NU],
  input  logic [NU-1:0]   fill_en,
  input  logic [RW-1:0]   fill_reg [NU],
  output logic [LENW-1:0] cnt [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_inc, hit_fill;

    always_comb begin
      hit_inc  = 1'b0;
      hit_fill = 1'b0;
      for (int u = 0; u < NU; u++) begin
        if (inc_en[u] && inc_reg[u] == RW'(g))   hit_inc  = 1'b1;
        if (fill_en[u] && fill_reg[u] == RW'(g)) hit_fill = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                               cnt[g] <= LENW'(VLMAX);
      else if (clr_en && clr_reg == RW'(g))     cnt[g] <= '0;
      else if (hit_fill)                        cnt[g] <= LENW'(VLMAX);
      else if (hit_inc)                         cnt[g] <= cnt[g] + LENW'(1);
    end

    // R4: no strobe may count past a full register
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_inc |-> (cnt[g] < LENW'(VLMAX)));
  end
endmodule

// File: rtl/vchain_unit.sv
module vchain_unit #(
  parameter int LAT     = 6,
  parameter bit HAS_SRC = 1'b1,
  parameter int RW      = 3,
  parameter int LENW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [RW-1:0]   st_vd,
  input  logic [RW-1:0]   st_vs1,
  input  logic [RW-1:0]   st_vs2,
  input  logic [LENW-1:0] st_len,
  input  logic [LENW-1:0] cnt_vs1,
  input  logic [LENW-1:0] cnt_vs2,
  output logic            busy,
  output logic [RW-1:0]   vd,
  output logic [RW-1:0]   vs1,
  output logic [RW-1:0]   vs2,
  output logic            adv,
  output logic [LENW-1:0] idx,
  output logic            wr,
  output logic            fin
);
  logic [LENW-1:0] len;
  logic [LAT-1:0]  pipe;
  logic            src_ok;

  always_comb begin
    if (HAS_SRC)
      src_ok = (vs1 == vd || cnt_vs1 > idx) && (vs2 == vd || cnt_vs2 > idx);
    else
      src_ok = 1'b1;
  end

  assign adv = busy && (idx < len) && src_ok;
  assign wr  = pipe[LAT-1];
  assign fin = busy && (idx == len) && (pipe[LAT-2:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      vd   <= '0;
      vs1  <= '0;
      vs2  <= '0;
      len  <= '0;
      idx  <= '0;
      pipe <= '0;
    end else begin
      pipe <= {pipe[LAT-2:0], adv};
      if (start) begin
        busy <= 1'b1;
        vd   <= st_vd;
        vs1  <= st_vs1;
        vs2  <= st_vs2;
        len  <= st_len;
        idx  <= '0;
      end else begin
        if (fin) busy <= 1'b0;
        if (adv) idx  <= idx + LENW'(1);
      end
    end
  end

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (idx == $past(idx) + LENW'(1)));
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_wr_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> busy);
endmodule

// File: rtl/vchain_issue.sv
module vchain_issue
  import vchain_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int VLMAX   = 16,
  parameter int LAT_LD  = 12,
  parameter int LAT_MUL = 7,
  parameter int LAT_ADD = 6,
  localparam int RW     = $clog2(NREG),
  localparam int LENW   = $clog2(VLMAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             in_op,
  input  logic [RW-1:0]          in_vd,
  input  logic [RW-1:0]          in_vs1,
  input  logic [RW-1:0]          in_vs2,
  input  logic [LENW-1:0]        in_len,
  output logic [NUNITS-1:0]      unit_start,
  output logic [NUNITS-1:0]      unit_adv,
  output logic [NUNITS*LENW-1:0] unit_idx,
  output logic [NUNITS-1:0]      unit_wr
);
  logic [NUNITS-1:0] u_busy, u_fin;
  logic [RW-1:0]     u_vd  [NUNITS];
  logic [RW-1:0]     u_vs1 [NUNITS];
  logic [RW-1:0]     u_vs2 [NUNITS];
  logic [LENW-1:0]   cnt   [NREG];
  logic              hazard, fire;
  int                new_u;

  always_comb begin
    new_u  = unit_of(in_op);
    hazard = 1'b0;
    for (int u = 0; u < NUNITS; u++) begin
      if (u_busy[u]) begin
        if (u == new_u)         hazard = 1'b1;  // structural
        if (u_vd[u] == in_vd)   hazard = 1'b1;  // write after write
        if (u != 0 && (u_vs1[u] == in_vd || u_vs2[u] == in_vd))
          hazard = 1'b1;                        // write after read
      end
    end
  end

  assign in_ready = !hazard;
  assign fire     = in_valid && in_ready;

  for (genvar g = 0; g < NUNITS; g++) begin : g_unit
    localparam int LAT_G = (g == 0) ? LAT_LD : (g == 1) ? LAT_MUL : LAT_ADD;

    assign unit_start[g] = fire && (new_u == g);

    vchain_unit #(
      .LAT    (LAT_G),
      .HAS_SRC(g != 0),
      .RW     (RW),
      .LENW   (LENW)
    ) u_fu (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (unit_start[g]),
      .st_vd  (in_vd),
      .st_vs1 (in_vs1),
      .st_vs2 (in_vs2),
      .st_len (in_len),
      .cnt_vs1(cnt[u_vs1[g]]),
      .cnt_vs2(cnt[u_vs2[g]]),
      .busy   (u_busy[g]),
      .vd     (u_vd[g]),
      .vs1    (u_vs1[g]),
      .vs2    (u_vs2[g]),
      .adv    (unit_adv[g]),
      .idx    (unit_idx[g*LENW +: LENW]),
      .wr     (unit_wr[g]),
      .fin    (u_fin[g])
    );

    assert_no_waw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (u_busy[g] && fire) |-> (in_vd != u_vd[g]));
  end

  vchain_avail #(
    .NREG (NREG),
    .VLMAX(VLMAX),
    .NU   (NUNITS)
  ) u_avail (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (fire),
    .clr_reg (in_vd),
    .inc_en  (unit_wr),
    .inc_reg (u_vd),
    .fill_en (u_fin),
    .fill_reg(u_vd),
    .cnt     (cnt)
  );

  assert_one_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_start));
endmodule

// File: tb/vchain_issue_tb.sv
module vchain_issue_tb;
  localparam int LW = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_op = '0;
  logic [2:0] in_vd = '0, in_vs1 = '0, in_vs2 = '0;
  logic [LW-1:0] in_len = '0;
  logic [2:0] unit_start, unit_adv, unit_wr;
  logic [3*LW-1:0] unit_idx;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int lat [3] = '{12, 7, 6};
  int exp_cyc [3][$];
  int exp_idx [3][$];
  int wr_due  [3][$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vchain_issue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_vd(in_vd), .in_vs1(in_vs1), .in_vs2(in_vs2),
    .in_len(in_len), .unit_start(unit_start), .unit_adv(unit_adv),
    .unit_idx(unit_idx), .unit_wr(unit_wr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push_run(input int u, input int first, input int len);
    for (int i = 0; i < len; i++) begin
      exp_cyc[u].push_back(first + i);
      exp_idx[u].push_back(i);
    end
  endtask

  // Driver: offer at a negedge, hold until accepted, return the transfer cycle.
  task automatic issue(input logic [1:0] op, input int vd, input int vs1,
                       input int vs2, input int len, input int unit, output int acc);
    in_op = op; in_vd = 3'(vd); in_vs1 = 3'(vs1); in_vs2 = 3'(vs2);
    in_len = LW'(len); in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    acc = cyc;
    chk(unit_start == 3'(1 << unit), "R2 start pulse", int'(unit_start), 1 << unit);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  // Monitor: compare each advance and write strobe against the scoreboard.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        for (int u = 0; u < 3; u++) begin
          if (unit_adv[u]) begin
            if (exp_cyc[u].size() == 0) begin
              chk(1'b0, "R3 unexpected advance", cyc, -1);
            end else begin
              int ec, ei, ai;
              ec = exp_cyc[u].pop_front();
              ei = exp_idx[u].pop_front();
              ai = int'(unit_idx[u*LW +: LW]);
              chk(ec == cyc, "R5 advance cycle", cyc, ec);
              chk(ei == ai, "R3 advance index", ai, ei);
            end
            wr_due[u].push_back(cyc + lat[u]);
          end
          while (wr_due[u].size() != 0 && wr_due[u][0] < cyc) begin
            chk(1'b0, "R4 missing write strobe", cyc, wr_due[u][0]);
            void'(wr_due[u].pop_front());
          end
          if (unit_wr[u]) begin
            if (wr_due[u].size() != 0 && wr_due[u][0] == cyc) begin
              chk(1'b1, "R4 write strobe", cyc, cyc);
              void'(wr_due[u].pop_front());
            end else begin
              chk(1'b0, "R4 write strobe timing", cyc,
                  wr_due[u].size() != 0 ? wr_due[u][0] : -1);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a0, a1, a2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(unit_start == 3'b0 && unit_adv == 3'b0 && unit_wr == 3'b0,
        "R1 outputs idle", int'({unit_start, unit_adv, unit_wr}), 0);
    @(negedge clk);

    // R5/R9: chained load v1 -> mul v3=v1*v2 -> add v5=v3+v4, 16 elements
    issue(2'd0, 1, 0, 0, 16, 0, a0);
    push_run(0, a0 + 1, 16);
    issue(2'd1, 3, 1, 2, 16, 1, a1);
    issue(2'd2, 5, 3, 4, 16, 2, a2);
    chk(a1 == a0 + 1, "R9 multiply transfers back to back", a1, a0 + 1);
    chk(a2 == a1 + 1, "R9 add transfers back to back", a2, a1 + 1);
    push_run(1, a0 + 14, 16);
    push_run(2, a0 + 22, 16);
    repeat (60) @(negedge clk);

    // R11: add on idle registers runs at once beside a load
    issue(2'd0, 1, 0, 0, 4, 0, a0);
    push_run(0, a0 + 1, 4);
    issue(2'd2, 6, 2, 4, 4, 2, a1);
    push_run(2, a1 + 1, 4);
    chk(a1 == a0 + 1, "R11 independent add transfers", a1, a0 + 1);
    drain();

    // R6: second load waits for the first's final write
    issue(2'd0, 1, 0, 0, 4, 0, a0);
    push_run(0, a0 + 1, 4);
    issue(2'd0, 2, 0, 0, 2, 0, a1);
    push_run(0, a1 + 1, 2);
    chk(a1 == a0 + 17, "R6 structural release cycle", a1, a0 + 17);
    drain();

    // R7: load into the destination of a running multiply
    issue(2'd1, 3, 1, 2, 4, 1, a0);
    push_run(1, a0 + 1, 4);
    issue(2'd0, 3, 0, 0, 2, 0, a1);
    push_run(0, a1 + 1, 2);
    chk(a1 == a0 + 12, "R7 write-after-write release cycle", a1, a0 + 12);
    drain();

    // R8: load into a source of a running add
    issue(2'd2, 5, 6, 7, 4, 2, a0);
    push_run(2, a0 + 1, 4);
    issue(2'd0, 6, 0, 0, 1, 0, a1);
    push_run(0, a1 + 1, 1);
    chk(a1 == a0 + 11, "R8 write-after-read release cycle", a1, a0 + 11);
    drain();

    // R10: multiply reading its own destination does not wait
    issue(2'd1, 2, 2, 4, 3, 1, a0);
    push_run(1, a0 + 1, 3);
    drain();

    // R2: reserved code 3 goes to the add unit
    issue(2'd3, 7, 1, 2, 2, 2, a0);
    push_run(2, a0 + 1, 2);
    drain();

    for (int u = 0; u < 3; u++) begin
      chk(exp_cyc[u].size() == 0, "R3 all expected advances seen", exp_cyc[u].size(), 0);
      chk(wr_due[u].size() == 0, "R4 all write strobes seen", wr_due[u].size(), 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule